// File: doc/BRIEF.md
# Dual-Rate Port Data Adapter

This block connects one memory port's external data lanes to a 72-bit internal word path. A static mode input selects double-data-rate or single-data-rate operation. In single-rate mode every transfer is a full 72-bit word taken on the rising edge of the true clock. In double-rate mode the external lanes carry 36-bit halves. One half is exchanged on the rising edge of the true clock and the other on the rising edge of the complementary clock.

On the write side, the adapter joins the two halves and their byte enables into one word. It hands that word to the internal datapath with a single-cycle strobe. On the read side, it takes a word from the array and drives it out. In single-rate mode the read path is flow-through or pipelined. In double-rate mode the word leaves as two halves on successive clock edges.

Top module: `ddr_sdr_port_adapter`

## Requirements
- R1: While the synchronous active-high reset is applied, `int_wr_valid` and `ext_dout_valid` are low and `ext_dout` is all zeros.
- R2: In single-rate mode (`ddr_mode`=0), if `ext_wr_en` is high at a true-clock rise k, then for the one cycle after rise k `int_wr_valid` is high, `int_wr_data` equals `ext_din` and `int_wr_be` equals `ext_be`, all as sampled at rise k.
- R3: In double-rate mode, a write accepted at true-clock rise k takes its upper half from `ext_din[35:0]`/`ext_be[3:0]` at rise k. It takes its lower half from the same lanes at the following complementary-clock rise. For the one cycle after rise k+1, `int_wr_data` = {upper, lower} and `int_wr_be` = {upper enables, lower enables}. Bit i of `int_wr_be` covers data bits 9i+8 down to 9i.
- R4: `ext_wr_en` is sampled only on the true clock. A pulse that is high only while the true clock is high (and is therefore seen only at a complementary-clock rise) produces no write strobe.
- R5: Double-rate writes on consecutive cycles produce one joined word per cycle, in the order the writes were issued.
- R6: In single-rate flow-through mode (`pipe_sel`=0), `int_rd_valid` high at rise k makes `ext_dout` equal `int_rd_data` with `ext_dout_valid` high for the one cycle after rise k.
- R7: In single-rate pipelined mode (`pipe_sel`=1), the same read appears one cycle later, in the cycle after rise k+1.
- R8: In double-rate mode, a read word sampled at rise k is driven on `ext_dout[35:0]`. Bits [71:36] of the word are driven from rise k while the true clock is high. Bits [35:0] of the word are driven from the following complementary-clock rise. `ext_dout[71:36]` is zero and `ext_dout_valid` is high for that whole cycle.
- R9: `pipe_sel` has no effect in double-rate mode: read timing matches R8 for either value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | True clock |
| clk_n | input | 1 | Complementary clock, used in double-rate mode |
| rst | input | 1 | Synchronous active-high reset |
| ddr_mode | input | 1 | Static mode: 1 double-rate, 0 single-rate |
| pipe_sel | input | 1 | Single-rate read path: 0 flow-through, 1 pipelined |
| ext_wr_en | input | 1 | Write request, sampled on true clock |
| ext_din | input | 72 | External write data; double-rate halves use [35:0] |
| ext_be | input | 8 | External byte enables; double-rate halves use [3:0] |
| int_wr_valid | output | 1 | One-cycle write strobe to internal datapath |
| int_wr_data | output | 72 | Joined write word |
| int_wr_be | output | 8 | Merged byte enables, one per 9 bits |
| int_rd_valid | input | 1 | Read word valid from array |
| int_rd_data | input | 72 | Read word from array |
| ext_dout_valid | output | 1 | External read data valid |
| ext_dout | output | 72 | External read data; double-rate halves on [35:0] |

## Verification
Each result is due a fixed number of true-clock cycles after its stimulus is sampled. A single-rate write, a flow-through read and a double-rate read are due in the cycle after the sampling edge. A double-rate write and a pipelined read are due one cycle later. The driver tasks stamp every expected item with its due cycle and push it into a queue. The monitors sample one nanosecond after each true-clock rise and compare the stamp with the current cycle count. A strobe that arrives early, late or without an expected item is reported. Double-rate reads are also sampled one nanosecond after the complementary-clock rise, so each half is checked in its own phase.

// File: rtl/pa_pkg.sv
package pa_pkg;
    localparam int HALF_W    = 36;
    localparam int WORD_W    = 2 * HALF_W;
    localparam int LANE_W    = 9;
    localparam int BE_W      = WORD_W / LANE_W;
    localparam int BE_HALF_W = BE_W / 2;

    typedef struct packed {
        logic [WORD_W-1:0] data;
        logic [BE_W-1:0]   be;
    } wr_word_t;

    function automatic wr_word_t join_halves(
        input logic [HALF_W-1:0]    up_d,
        input logic [HALF_W-1:0]    lo_d,
        input logic [BE_HALF_W-1:0] up_be,
        input logic [BE_HALF_W-1:0] lo_be
    );
        wr_word_t w;
        w.data = {up_d, lo_d};
        w.be   = {up_be, lo_be};
        return w;
    endfunction
endpackage

// File: rtl/pa_wr_joiner.sv
module pa_wr_joiner
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] din,
    input  logic [BE_W-1:0]   be,
    output logic              out_valid,
    output wr_word_t          out_word
);
    logic [HALF_W-1:0]    up_d_q;
    logic [BE_HALF_W-1:0] up_be_q;
    logic [HALF_W-1:0]    lo_d_q;
    logic [BE_HALF_W-1:0] lo_be_q;
    logic                 pend_q;
    wr_word_t             joined;

    assign joined = join_halves(up_d_q, lo_d_q, up_be_q, lo_be_q);

    // True-clock side: first half and request capture, word output.
    always_ff @(posedge clk) begin
        if (rst) begin
            up_d_q    <= '0;
            up_be_q   <= '0;
            pend_q    <= 1'b0;
            out_valid <= 1'b0;
            out_word  <= '0;
        end else begin
            pend_q  <= ddr_mode & wr_en;
            up_d_q  <= din[HALF_W-1:0];
            up_be_q <= be[BE_HALF_W-1:0];
            if (ddr_mode) begin
                out_valid <= pend_q;
                if (pend_q) out_word <= joined;
            end else begin
                out_valid <= wr_en;
                if (wr_en) begin
                    out_word.data <= din;
                    out_word.be   <= be;
                end
            end
        end
    end

    // Complementary-clock side: second half capture.
    always_ff @(posedge clk_n) begin
        if (rst) begin
            lo_d_q  <= '0;
            lo_be_q <= '0;
        end else begin
            lo_d_q  <= din[HALF_W-1:0];
            lo_be_q <= be[BE_HALF_W-1:0];
        end
    end
endmodule

// File: rtl/pa_rd_serializer.sv
module pa_rd_serializer
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic              pipe_sel,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data
);
    logic              v1_q, v2_q;
    logic [WORD_W-1:0] w1_q, w2_q;
    logic [HALF_W-1:0] lo_q;
    logic [HALF_W-1:0] half_out;

    always_ff @(posedge clk) begin
        if (rst) begin
            v1_q <= 1'b0;
            v2_q <= 1'b0;
            w1_q <= '0;
            w2_q <= '0;
        end else begin
            v1_q <= in_valid;
            if (in_valid) w1_q <= in_word;
            v2_q <= v1_q;
            if (v1_q) w2_q <= w1_q;
        end
    end

    always_ff @(posedge clk_n) begin
        if (rst) lo_q <= '0;
        else     lo_q <= w1_q[HALF_W-1:0];
    end

    // Upper half during the true-clock high phase, lower half after clk_n rises.
    assign half_out = clk ? w1_q[WORD_W-1:HALF_W] : lo_q;

    always_comb begin
        if (ddr_mode) begin
            out_valid = v1_q;
            out_data  = {{HALF_W{1'b0}}, half_out};
        end else if (pipe_sel) begin
            out_valid = v2_q;
            out_data  = w2_q;
        end else begin
            out_valid = v1_q;
            out_data  = w1_q;
        end
        if (rst) out_data = '0;
    end
endmodule

// File: rtl/ddr_sdr_port_adapter.sv
module ddr_sdr_port_adapter
    import pa_pkg::*;
(
    input  logic              clk,
    input  logic              clk_n,
    input  logic              rst,
    input  logic              ddr_mode,
    input  logic              pipe_sel,
    input  logic              ext_wr_en,
    input  logic [WORD_W-1:0] ext_din,
    input  logic [BE_W-1:0]   ext_be,
    output logic              int_wr_valid,
    output logic [WORD_W-1:0] int_wr_data,
    output logic [BE_W-1:0]   int_wr_be,
    input  logic              int_rd_valid,
    input  logic [WORD_W-1:0] int_rd_data,
    output logic              ext_dout_valid,
    output logic [WORD_W-1:0] ext_dout
);
    wr_word_t wr_word;

    pa_wr_joiner u_wr (
        .clk       (clk),
        .clk_n     (clk_n),
        .rst       (rst),
        .ddr_mode  (ddr_mode),
        .wr_en     (ext_wr_en),
        .din       (ext_din),
        .be        (ext_be),
        .out_valid (int_wr_valid),
        .out_word  (wr_word)
    );

    assign int_wr_data = wr_word.data;
    assign int_wr_be   = wr_word.be;

    pa_rd_serializer u_rd (
        .clk       (clk),
        .clk_n     (clk_n),
        .rst       (rst),
        .ddr_mode  (ddr_mode),
        .pipe_sel  (pipe_sel),
        .in_valid  (int_rd_valid),
        .in_word   (int_rd_data),
        .out_valid (ext_dout_valid),
        .out_data  (ext_dout)
    );
endmodule

// File: rtl/port_adapter_chk.sv
module port_adapter_chk
    import pa_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ddr_mode,
    input logic              pipe_sel,
    input logic              ext_wr_en,
    input logic [WORD_W-1:0] ext_din,
    input logic              int_wr_valid,
    input logic [WORD_W-1:0] int_wr_data,
    input logic              int_rd_valid,
    input logic              ext_dout_valid
);
    assert_sdr_wr_src_R2: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && int_wr_valid) |-> $past(ext_wr_en));

    assert_sdr_wr_data_R2: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && int_wr_valid) |-> (int_wr_data == $past(ext_din)));

    assert_ddr_wr_lat_R3: assert property (@(posedge clk) disable iff (rst)
        (ddr_mode && int_wr_valid) |-> $past(ext_wr_en, 2));

    assert_flow_rd_R6: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && !pipe_sel && ext_dout_valid) |-> $past(int_rd_valid));

    assert_pipe_rd_R7: assert property (@(posedge clk) disable iff (rst)
        (!ddr_mode && pipe_sel && ext_dout_valid) |-> $past(int_rd_valid, 2));

    assert_ddr_rd_R9: assert property (@(posedge clk) disable iff (rst)
        (ddr_mode && ext_dout_valid) |-> $past(int_rd_valid));
endmodule

bind ddr_sdr_port_adapter port_adapter_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .ddr_mode       (ddr_mode),
    .pipe_sel       (pipe_sel),
    .ext_wr_en      (ext_wr_en),
    .ext_din        (ext_din),
    .int_wr_valid   (int_wr_valid),
    .int_wr_data    (int_wr_data),
    .int_rd_valid   (int_rd_valid),
    .ext_dout_valid (ext_dout_valid)
);

// File: tb/ddr_sdr_port_adapter_test.sv
module ddr_sdr_port_adapter_test;
    import pa_pkg::*;

    typedef struct {
        int                due;
        logic [WORD_W-1:0] d;
        logic [BE_W-1:0]   b;
    } exp_t;

    logic              clk = 1'b0;
    logic              clk_n;
    logic              rst = 1'b1;
    logic              ddr_mode = 1'b0;
    logic              pipe_sel = 1'b0;
    logic              ext_wr_en = 1'b0;
    logic [WORD_W-1:0] ext_din = '0;
    logic [BE_W-1:0]   ext_be = '0;
    logic              int_wr_valid;
    logic [WORD_W-1:0] int_wr_data;
    logic [BE_W-1:0]   int_wr_be;
    logic              int_rd_valid = 1'b0;
    logic [WORD_W-1:0] int_rd_data = '0;
    logic              ext_dout_valid;
    logic [WORD_W-1:0] ext_dout;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string wr_req = "R2";
    string rd_req = "R6";
    exp_t  wr_q[$];
    exp_t  rd_q[$];

    always #2 clk = ~clk;
    assign clk_n = ~clk;
    always @(posedge clk) cyc++;

    ddr_sdr_port_adapter uut (
        .clk(clk), .clk_n(clk_n), .rst(rst), .ddr_mode(ddr_mode), .pipe_sel(pipe_sel),
        .ext_wr_en(ext_wr_en), .ext_din(ext_din), .ext_be(ext_be),
        .int_wr_valid(int_wr_valid), .int_wr_data(int_wr_data), .int_wr_be(int_wr_be),
        .int_rd_valid(int_rd_valid), .int_rd_data(int_rd_data),
        .ext_dout_valid(ext_dout_valid), .ext_dout(ext_dout)
    );

    task automatic check(input string req, input logic ok, input logic [WORD_W-1:0] act,
                         input logic [WORD_W-1:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cyc);
        end
    endtask

    // Write monitor.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (int_wr_valid) begin
                if (wr_q.size() == 0) begin
                    check(wr_req, 1'b0, int_wr_data, '0);
                end else begin
                    exp_t e;
                    e = wr_q.pop_front();
                    check(wr_req, int_wr_data == e.d, int_wr_data, e.d);
                    check(wr_req, int_wr_be == e.b, WORD_W'(int_wr_be), WORD_W'(e.b));
                    check(wr_req, cyc == e.due, WORD_W'(cyc), WORD_W'(e.due));
                end
            end else if (wr_q.size() != 0 && wr_q[0].due <= cyc) begin
                exp_t e;
                e = wr_q.pop_front();
                check(wr_req, 1'b0, '0, e.d);
            end
        end
    end

    // Read monitor.
    always @(posedge clk) begin
        #1;
        if (!rst) begin
            if (ext_dout_valid) begin
                if (rd_q.size() == 0) begin
                    check(rd_req, 1'b0, ext_dout, '0);
                end else begin
                    exp_t e;
                    e = rd_q.pop_front();
                    check(rd_req, cyc == e.due, WORD_W'(cyc), WORD_W'(e.due));
                    if (ddr_mode) begin
                        check("R8", ext_dout == {{HALF_W{1'b0}}, e.d[WORD_W-1:HALF_W]},
                              ext_dout, {{HALF_W{1'b0}}, e.d[WORD_W-1:HALF_W]});
                        #2;
                        check("R8", ext_dout == {{HALF_W{1'b0}}, e.d[HALF_W-1:0]},
                              ext_dout, {{HALF_W{1'b0}}, e.d[HALF_W-1:0]});
                        check("R8", ext_dout_valid, WORD_W'(ext_dout_valid), 1);
                    end else begin
                        check(rd_req, ext_dout == e.d, ext_dout, e.d);
                    end
                end
            end else if (rd_q.size() != 0 && rd_q[0].due <= cyc) begin
                exp_t e;
                e = rd_q.pop_front();
                check(rd_req, 1'b0, '0, e.d);
            end
        end
    end

    task automatic do_reset(input logic ddr, input logic pipe);
        @(negedge clk);
        rst = 1'b1;
        ddr_mode = ddr;
        pipe_sel = pipe;
        repeat (3) @(posedge clk);
        #1;
        check("R1", !int_wr_valid, WORD_W'(int_wr_valid), 0);
        check("R1", !ext_dout_valid, WORD_W'(ext_dout_valid), 0);
        check("R1", ext_dout == '0, ext_dout, '0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic sdr_write(input logic [WORD_W-1:0] d, input logic [BE_W-1:0] b);
        exp_t e;
        @(negedge clk); #1;
        ext_wr_en = 1'b1; ext_din = d; ext_be = b;
        e.due = cyc + 1; e.d = d; e.b = b;
        wr_q.push_back(e);
        @(posedge clk); #1;
        ext_wr_en = 1'b0;
    endtask

    task automatic ddr_write(input logic [HALF_W-1:0] up, input logic [HALF_W-1:0] lo,
                             input logic [BE_HALF_W-1:0] ub, input logic [BE_HALF_W-1:0] lb);
        exp_t e;
        @(negedge clk); #1;
        ext_wr_en = 1'b1;
        ext_din = {{HALF_W{1'b1}}, up};
        ext_be = {{BE_HALF_W{1'b1}}, ub};
        e.due = cyc + 2; e.d = {up, lo}; e.b = {ub, lb};
        wr_q.push_back(e);
        @(posedge clk); #1;
        ext_wr_en = 1'b0;
        ext_din = {{HALF_W{1'b0}}, lo};
        ext_be = {{BE_HALF_W{1'b0}}, lb};
    endtask

    task automatic rd_word(input logic [WORD_W-1:0] d, input int lat);
        exp_t e;
        @(negedge clk); #1;
        int_rd_valid = 1'b1; int_rd_data = d;
        e.due = cyc + lat; e.d = d; e.b = '0;
        rd_q.push_back(e);
        @(posedge clk); #1;
        int_rd_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (5) @(posedge clk);
        #1;
        check("R5", wr_q.size() == 0, WORD_W'(wr_q.size()), 0);
        check("R8", rd_q.size() == 0, WORD_W'(rd_q.size()), 0);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired, run hung");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R2, R6: single-rate writes and flow-through reads
        do_reset(1'b0, 1'b0);
        wr_req = "R2"; rd_req = "R6";
        sdr_write(72'h123456789ABCDEF012, 8'hA5);
        sdr_write(72'hFFFFFFFFFFFFFFFFFF, 8'hFF);
        sdr_write(72'h000000000000000001, 8'h01);
        rd_word(72'hCAFEBABE0123456789, 1);
        rd_word(72'h800000000000000001, 1);
        drain();

        // R7: single-rate pipelined reads
        do_reset(1'b0, 1'b1);
        rd_req = "R7";
        rd_word(72'h0F0F0F0F0F0F0F0F0F, 2);
        rd_word(72'hF0F0F0F0F0F0F0F0F0, 2);
        drain();

        // R3, R5, R8: double-rate writes back to back, reads
        do_reset(1'b1, 1'b0);
        wr_req = "R3"; rd_req = "R8";
        ddr_write(36'h876543210, 36'h0FEDCBA98, 4'hC, 4'h3);
        wr_req = "R5";
        ddr_write(36'hAAAAAAAAA, 36'h555555555, 4'h9, 4'h6);
        ddr_write(36'h000000001, 36'h800000000, 4'h1, 4'h8);
        rd_word(72'hDEADBEEF0011223344, 1);
        drain();

        // R4: write request seen only at a complementary-clock rise
        wr_req = "R4";
        @(posedge clk); #1;
        ext_wr_en = 1'b1;
        @(negedge clk); #1;
        ext_wr_en = 1'b0;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); #1;
            check("R4", !int_wr_valid, WORD_W'(int_wr_valid), 0);
        end

        // R9: pipe_sel ignored in double-rate mode
        do_reset(1'b1, 1'b1);
        rd_req = "R9";
        rd_word(72'h13579BDF02468ACE11, 1);
        rd_word(72'h2468ACE013579BDF22, 1);
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule